// File: doc/BRIEF.md
# Two-Way Write-Back Cache Tag Controller

This block keeps the tag state of a two-way set-associative data cache that runs a write-back, write-allocate policy. It holds no data array. At most one memory reference arrives per cycle as a 32-bit byte address with a flag that marks it as a load or a store. The block cuts the address into block offset, set index and tag. It compares the tag against both ways of the selected set and then reports a hit, a miss that evicts a clean line, or a miss that evicts a dirty line. It also names the way that was used.

Tags start at zero and count as valid from reset, so no per-line valid bit exists. Each set keeps one tag and one dirty bit per way, plus one recency bit that points at the way to replace next. Five running 64-bit counters record references, misses, dirty evictions, bytes fetched to fill lines and bytes written back. A performance model or a trace-driven test harness can read these counters to get miss rate and memory traffic without moving any data.

Capacity and block size are parameters given as base-2 logarithms. The defaults are 32 KB with 64-byte blocks, which gives 256 sets, 6 offset bits, 8 index bits and 18 tag bits.

Top module: `wb2way_tag_ctrl`

## Requirements
- R1: The address splits into offset `in_addr[LOG_BLOCK-1:0]`, index as the next LOG_SIZE-LOG_BLOCK-1 bits, and tag as all remaining upper bits. With the defaults these are offset [5:0], index [13:6] and tag [31:14]. Addresses that differ only in offset bits give the same outcome.
- R2: A synchronous reset clears every tag to zero, every dirty bit and recency bit to zero, and all counters to zero, and it drops `out_valid`. After reset every way counts as holding tag zero.
- R3: A reference taken with `in_valid` high produces `out_valid` high on the next cycle, and only then. `out_kind` is encoded as 0 = hit, 1 = miss evicting a clean line, 2 = miss evicting a dirty line. Code 3 never appears.
- R4: A reference hits when the tag of either way in its set matches, whether it is a load or a store. If both ways match, way 0 is reported.
- R5: Every reference, hit or fill, sets the recency bit of its set to point at the way it did not touch.
- R6: On a miss, the way named by the recency bit is replaced with the new tag and is reported on `out_way`. On a hit, `out_way` gives the matching way.
- R7: A store, hit or miss, makes its way dirty. A load miss leaves the filled way clean. A load hit leaves the dirty bit unchanged.
- R8: A miss is reported as dirty (code 2) exactly when the replaced way was dirty. Otherwise it is reported as clean (code 1).
- R9: `cnt_access` counts every reference, `cnt_miss` counts every miss and `cnt_dirty_evict` counts every dirty miss. Each counter changes in the same cycle as the matching outcome and saturates at all ones.
- R10: `cnt_fill_bytes` grows by 2^LOG_BLOCK on every miss. `cnt_wb_bytes` grows by 2^LOG_BLOCK on every dirty eviction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A reference is presented this cycle |
| in_addr | input | 32 | Byte address of the reference |
| in_store | input | 1 | 1 = store, 0 = load |
| out_valid | output | 1 | Outcome fields hold a result this cycle |
| out_kind | output | 2 | 0 hit, 1 clean miss, 2 dirty miss |
| out_way | output | 1 | Way that was hit or replaced |
| cnt_access | output | 64 | Reference count |
| cnt_miss | output | 64 | Miss count |
| cnt_dirty_evict | output | 64 | Dirty eviction count |
| cnt_fill_bytes | output | 64 | Bytes fetched to fill lines |
| cnt_wb_bytes | output | 64 | Bytes written back |

## Verification
A wrong recency bit shows up at the next miss to that set: the reported way is wrong. A wrong tag turns a later hit into a miss, or the reverse, at the next reference to that line. A lost or spurious dirty bit changes the outcome code from 1 to 2, or from 2 to 1, when that line is next evicted, and it shifts the write-back counter in the same cycle. Such faults can stay hidden for many references. For that reason the stimulus revisits a few sets, with back-to-back references to the same set and dense reuse of a small group of tags, so that any divergence in state reaches the outcome ports within a few cycles.

// File: rtl/wb2way_tag_ctrl.sv
module wb2way_tag_ctrl #(
  parameter int LOG_SIZE  = 15,
  parameter int LOG_BLOCK = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] in_addr,
  input  logic        in_store,
  output logic        out_valid,
  output logic [1:0]  out_kind,
  output logic        out_way,
  output logic [63:0] cnt_access,
  output logic [63:0] cnt_miss,
  output logic [63:0] cnt_dirty_evict,
  output logic [63:0] cnt_fill_bytes,
  output logic [63:0] cnt_wb_bytes
);
  localparam int IDX_W = LOG_SIZE - LOG_BLOCK - 1;
  localparam int TAG_W = 32 - LOG_BLOCK - IDX_W;
  localparam int SETS  = 1 << IDX_W;
  localparam logic [63:0] BLK = 64'd1 << LOG_BLOCK;

  logic [TAG_W-1:0] tag_q [2][SETS];
  logic [SETS-1:0]  dirty_q [2];
  logic [SETS-1:0]  lru_q;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic hit0, hit1, hit, way, victim, vdirty;

  assign idx    = in_addr[LOG_BLOCK +: IDX_W];
  assign tag    = in_addr[31 -: TAG_W];
  assign hit0   = tag_q[0][idx] == tag;
  assign hit1   = tag_q[1][idx] == tag;
  assign hit    = hit0 | hit1;
  assign victim = lru_q[idx];
  assign way    = hit ? !hit0 : victim;
  assign vdirty = dirty_q[victim][idx];

  function automatic logic [63:0] sat_add(input logic [63:0] a, input logic [63:0] b);
    logic [64:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[64] ? {64{1'b1}} : s[63:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[0][s] <= '0;
        tag_q[1][s] <= '0;
      end
      dirty_q[0]      <= '0;
      dirty_q[1]      <= '0;
      lru_q           <= '0;
      out_valid       <= 1'b0;
      out_kind        <= 2'd0;
      out_way         <= 1'b0;
      cnt_access      <= '0;
      cnt_miss        <= '0;
      cnt_dirty_evict <= '0;
      cnt_fill_bytes  <= '0;
      cnt_wb_bytes    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_way    <= way;
        out_kind   <= hit ? 2'd0 : (vdirty ? 2'd2 : 2'd1);
        lru_q[idx] <= !way;
        cnt_access <= sat_add(cnt_access, 64'd1);
        if (!hit) begin
          tag_q[way][idx] <= tag;
          cnt_miss        <= sat_add(cnt_miss, 64'd1);
          cnt_fill_bytes  <= sat_add(cnt_fill_bytes, BLK);
          if (vdirty) begin
            cnt_dirty_evict <= sat_add(cnt_dirty_evict, 64'd1);
            cnt_wb_bytes    <= sat_add(cnt_wb_bytes, BLK);
          end
        end
        if (!hit || in_store) dirty_q[way][idx] <= in_store;
      end
    end
  end
endmodule

// File: rtl/wb2way_tag_ctrl_chk.sv
module wb2way_tag_ctrl_chk #(
  parameter int LOG_BLOCK = 6
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        out_valid,
  input logic [1:0]  out_kind,
  input logic [63:0] cnt_access,
  input logic [63:0] cnt_miss,
  input logic [63:0] cnt_dirty_evict,
  input logic [63:0] cnt_fill_bytes,
  input logic [63:0] cnt_wb_bytes
);
  localparam logic [63:0] MAXV = {64{1'b1}};

  p_result_follows_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_kind_legal_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_kind != 2'd3);
  p_hit_keeps_miss_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == 2'd0) |-> $stable(cnt_miss));
  p_miss_bumps_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind != 2'd0 && $past(cnt_miss) != MAXV) |-> cnt_miss == $past(cnt_miss) + 64'd1);
  p_idle_access_r9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(cnt_access));
  p_dirty_bumps_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == 2'd2 && $past(cnt_dirty_evict) != MAXV) |-> cnt_dirty_evict == $past(cnt_dirty_evict) + 64'd1);
  p_fill_bytes_r10: assert property (@(posedge clk) disable iff (rst)
    ((cnt_miss >> (64 - LOG_BLOCK)) == 64'd0) |-> cnt_fill_bytes == (cnt_miss << LOG_BLOCK));
  p_wb_bytes_r10: assert property (@(posedge clk) disable iff (rst)
    ((cnt_dirty_evict >> (64 - LOG_BLOCK)) == 64'd0) |-> cnt_wb_bytes == (cnt_dirty_evict << LOG_BLOCK));
endmodule

bind wb2way_tag_ctrl wb2way_tag_ctrl_chk #(.LOG_BLOCK(LOG_BLOCK)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid), .out_kind(out_kind),
  .cnt_access(cnt_access), .cnt_miss(cnt_miss), .cnt_dirty_evict(cnt_dirty_evict),
  .cnt_fill_bytes(cnt_fill_bytes), .cnt_wb_bytes(cnt_wb_bytes));

// File: tb/tb_wb2way_tag_ctrl.sv
`timescale 1ns/1ps
module tb_wb2way_tag_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [31:0] in_addr = '0;
  logic in_store = 1'b0;
  logic out_valid, out_way;
  logic [1:0] out_kind;
  logic [63:0] cnt_access, cnt_miss, cnt_dirty_evict, cnt_fill_bytes, cnt_wb_bytes;

  always #10 clk = ~clk;

  wb2way_tag_ctrl dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr), .in_store(in_store),
    .out_valid(out_valid), .out_kind(out_kind), .out_way(out_way),
    .cnt_access(cnt_access), .cnt_miss(cnt_miss), .cnt_dirty_evict(cnt_dirty_evict),
    .cnt_fill_bytes(cnt_fill_bytes), .cnt_wb_bytes(cnt_wb_bytes));

  typedef struct {
    logic [1:0]  kind;
    logic        way;
    logic [63:0] acc, mis, dev, fil, wbb;
    string       req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [17:0] mt [2][256];
  logic        md [2][256];
  logic        ml [256];
  logic [63:0] e_acc, e_mis, e_dev, e_fil, e_wbb;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 256; s++) begin
      mt[0][s] = '0; mt[1][s] = '0; md[0][s] = 0; md[1][s] = 0; ml[s] = 0;
    end
    e_acc = 0; e_mis = 0; e_dev = 0; e_fil = 0; e_wbb = 0;
  endtask

  function automatic logic [31:0] mk(input logic [17:0] t, input logic [7:0] i, input logic [5:0] o);
    return {t, i, o};
  endfunction

  task automatic access(input logic [31:0] a, input bit st, input string req);
    exp_t e;
    logic [17:0] t;
    logic [7:0] i;
    logic w;
    t = a[31:14];
    i = a[13:6];
    @(negedge clk);
    e_acc++;
    if (mt[0][i] == t || mt[1][i] == t) begin
      w = (mt[0][i] == t) ? 1'b0 : 1'b1;
      e.kind = 2'd0;
      if (st) md[w][i] = 1;
    end else begin
      w = ml[i];
      e.kind = md[w][i] ? 2'd2 : 2'd1;
      e_mis++;
      e_fil += 64;
      if (md[w][i]) begin
        e_dev++;
        e_wbb += 64;
      end
      mt[w][i] = t;
      md[w][i] = st;
    end
    ml[i] = ~w;
    e.way = w; e.acc = e_acc; e.mis = e_mis; e.dev = e_dev; e.fil = e_fil; e.wbb = e_wbb;
    e.req = req;
    q.push_back(e);
    in_valid = 1'b1;
    in_addr  = a;
    in_store = st;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q.size() == 0) begin
        chk(0, "R3", "unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(out_kind == e.kind, e.req, "out_kind", out_kind, e.kind);
        chk(out_way == e.way, e.req, "out_way (R6)", out_way, e.way);
        chk(cnt_access == e.acc, "R9", "cnt_access", cnt_access, e.acc);
        chk(cnt_miss == e.mis, "R9", "cnt_miss", cnt_miss, e.mis);
        chk(cnt_dirty_evict == e.dev, "R8", "cnt_dirty_evict", cnt_dirty_evict, e.dev);
        chk(cnt_fill_bytes == e.fil, "R10", "cnt_fill_bytes", cnt_fill_bytes, e.fil);
        chk(cnt_wb_bytes == e.wbb, "R10", "cnt_wb_bytes", cnt_wb_bytes, e.wbb);
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: reset state at the ports
    chk(out_valid == 0, "R2", "out_valid after reset", out_valid, 0);
    chk(cnt_access == 0 && cnt_miss == 0 && cnt_fill_bytes == 0, "R2", "counters after reset",
        cnt_access | cnt_miss | cnt_fill_bytes, 0);
    // R2: tag zero hits right after reset; R4: double match reports way 0
    access(mk(18'd0, 8'd0, 6'd0), 0, "R2");
    access(mk(18'd0, 8'd1, 6'd8), 1, "R4");
    idle(1);
    // R3: no result without a reference
    @(negedge clk);
    chk(out_valid == 0, "R3", "out_valid while idle", out_valid, 0);
    // R1: offset bits do not affect the outcome
    access(mk(18'd5, 8'd3, 6'd0), 0, "R1");
    access(mk(18'd5, 8'd3, 6'd60), 1, "R1");
    access(mk(18'd5, 8'd4, 6'd0), 0, "R1");
    // R5 / R6: recency steering
    access(mk(18'd6, 8'd3, 6'd0), 0, "R6");
    access(mk(18'd5, 8'd3, 6'd4), 0, "R5");
    access(mk(18'd7, 8'd3, 6'd0), 0, "R5");
    access(mk(18'd6, 8'd3, 6'd0), 0, "R6");
    // R7 / R8: dirty tracking and classification
    access(mk(18'd9,  8'd10, 6'd0), 1, "R7");
    access(mk(18'd11, 8'd10, 6'd0), 0, "R7");
    access(mk(18'd12, 8'd10, 6'd0), 0, "R8");
    access(mk(18'd11, 8'd10, 6'd0), 1, "R7");
    access(mk(18'd12, 8'd10, 6'd0), 0, "R7");
    access(mk(18'd13, 8'd10, 6'd0), 0, "R8");
    access(mk(18'd14, 8'd10, 6'd0), 0, "R8");
    idle(3);
    // Dense mixed stream over a few sets and tags
    lfsr = 32'h1234_5678;
    for (int n = 0; n < 3000; n++) begin
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      access(mk({15'd0, lfsr[27:25]}, {6'd0, lfsr[21:20]}, lfsr[13:8]), lfsr[30], "R4");
      if (lfsr[17:15] == 3'd0) idle(1);
    end
    idle(4);
    chk(q.size() == 0, "R3", "results outstanding", q.size(), 0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule